// File: doc/BRIEF.md
# Packed 11-Bit Record Field Extractor

This block pulls one record out of a list of 11-bit records packed end to end in byte-addressed memory, with no gaps between them. The caller presents a base address and a record number and raises a one-cycle start strobe. If the number is within the configured limit, the block works out where the record begins from the number alone, with no scanning. It reads the two or three bytes that hold the record through a byte-wide synchronous read port. It then aligns the record and splits it into a 4-bit, a 5-bit and a 2-bit field.

If the number is above the limit, the block makes no memory access. It reports failure through an error flag and returns zero fields. In both cases a one-cycle done pulse marks the cycle in which the outputs are valid. The outputs then keep their values until the next done pulse.

The read port has one cycle of latency. Data for a read issued in one cycle is presented on `mem_rdata` in the following cycle.

Top module: `rx_rec_extract`

## Requirements
- R1: Record k occupies bit offsets 11k to 11k+10. Offset 0 is bit 7 (the MSB) of the byte at the base address, offset 8 is bit 7 of the next byte, and so on. Higher addresses hold later bits.
- R2: Within a record, the first 4 bits in offset order form `fld_hi` (its MSB first). The next 5 bits form `fld_mid` and the last 2 bits form `fld_lo`.
- R3: A valid access reads consecutive addresses, one read per cycle. The first address is base + floor(11k/8), modulo 2^ADDR_W.
- R4: The block issues exactly 2 reads when (11k mod 8) is 5 or less, and exactly 3 reads otherwise.
- R5: A record number greater than MAX_REC raises `err` (1 means failure) and issues no memory read.
- R6: When `err` is 1, all three field outputs are zero. A number equal to MAX_REC is accepted with `err` = 0.
- R7: `done` is high for one cycle. For a valid access it is high in the cycle N+2 cycles after the start edge, where N is the read count. For an out-of-range number it is high in the cycle right after the start edge.
- R8: A start that arrives while an access is in progress is ignored and does not change the result of that access.
- R9: `err` and the three field outputs change only in a cycle in which `done` is high, and they hold their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an access (taken only while idle) |
| base_addr | input | ADDR_W | Byte address of record 0 |
| rec_num | input | NUM_W | Record number to fetch |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| done | output | 1 | One-cycle pulse: outputs valid |
| err | output | 1 | 1 = record number out of range |
| fld_hi | output | 4 | First (most significant) field |
| fld_mid | output | 5 | Second field |
| fld_lo | output | 2 | Third field |

## Verification
Some properties are checked by assertions on every cycle. These are: zero fields whenever an error is reported, no read after an out-of-range start, consecutive addresses in back-to-back reads, and outputs held steady outside done pulses. The bench's scenarios are needed for the rest. They show that the fields match the packed bit layout, and that the read count follows the start bit within the byte. They also cover the exact done latency, acceptance at the limit, and that a start during a busy access is ignored. The bench reaches these by sweeping start offsets 0 through 7, several base addresses, the boundary at the maximum, and a start issued during an access.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam int REC_W   = 11;
  localparam int HI_W    = 4;
  localparam int MID_W   = 5;
  localparam int LO_W    = 2;
  localparam int BYTE_W  = 8;
  localparam int WIN_BYTES = 3;
  localparam int WIN_W   = WIN_BYTES * BYTE_W;
  localparam int WIDE_MAX_BIT = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_TAIL, ST_OUT} rx_state_t;

  typedef struct packed {
    logic [HI_W-1:0]  hi;
    logic [MID_W-1:0] mid;
    logic [LO_W-1:0]  lo;
  } rx_rec_t;
endpackage

// File: rtl/rx_locate.sv
module rx_locate #(
  parameter int ADDR_W  = 16,
  parameter int NUM_W   = 12,
  parameter int MAX_REC = 2047
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [NUM_W-1:0]  rec_num,
  output logic [ADDR_W-1:0] first_addr,
  output logic [2:0]        bit_sel,
  output logic              wide,
  output logic              over_max
);
  import rx_pkg::*;
  localparam int BO_W = NUM_W + 4;

  logic [BO_W-1:0] num_ext;
  logic [BO_W-1:0] bit_off;

  always_comb begin
    num_ext    = BO_W'(rec_num);
    // 11k = 8k + 2k + k
    bit_off    = (num_ext << 3) + (num_ext << 1) + num_ext;
    first_addr = base_addr + ADDR_W'(bit_off >> 3);
    bit_sel    = bit_off[2:0];
    wide       = (bit_off[2:0] > 3'(WIDE_MAX_BIT));
    over_max   = (rec_num > NUM_W'(MAX_REC));
  end
endmodule

// File: rtl/rx_window.sv
module rx_window #(
  parameter int WIN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift_en,
  input  logic [7:0]       din,
  output logic [WIN_W-1:0] win
);
  logic [WIN_W-1:0] win_d;

  always_comb begin
    win_d = win;
    if (clr)           win_d = '0;
    else if (shift_en) win_d = {win[WIN_W-9:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win <= '0;
    else        win <= win_d;
  end
endmodule

// File: rtl/rx_split.sv
module rx_split (
  input  logic [rx_pkg::WIN_W-1:0] win,
  input  logic                     wide,
  input  logic [2:0]               bit_sel,
  output rx_pkg::rx_rec_t          rec
);
  import rx_pkg::*;
  logic [WIN_W-1:0] aligned;
  logic [REC_W-1:0] bits;
  logic [4:0]       top;

  always_comb begin
    // put the first fetched byte at the top of the window
    aligned = wide ? win : {win[WIN_W-9:0], 8'h00};
    top     = 5'(WIN_W - 1) - 5'(bit_sel);
    bits    = aligned[top -: REC_W];
    rec.hi  = bits[REC_W-1 -: HI_W];
    rec.mid = bits[REC_W-1-HI_W -: MID_W];
    rec.lo  = bits[LO_W-1:0];
  end
endmodule

// File: rtl/rx_rec_extract.sv
module rx_rec_extract #(
  parameter int ADDR_W  = 16,
  parameter int NUM_W   = 12,
  parameter int MAX_REC = 2047
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [NUM_W-1:0]  rec_num,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              done,
  output logic              err,
  output logic [3:0]        fld_hi,
  output logic [4:0]        fld_mid,
  output logic [1:0]        fld_lo
);
  import rx_pkg::*;

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [ADDR_W-1:0] loc_addr;
  logic [2:0]        loc_bit;
  logic              loc_wide;
  logic              loc_over;

  rx_locate #(.ADDR_W(ADDR_W), .NUM_W(NUM_W), .MAX_REC(MAX_REC)) u_locate (
    .base_addr (base_addr),
    .rec_num   (rec_num),
    .first_addr(loc_addr),
    .bit_sel   (loc_bit),
    .wide      (loc_wide),
    .over_max  (loc_over)
  );

  rx_state_t         st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [2:0]        bit_q, bit_d;
  logic              wide_q, wide_d;
  logic [1:0]        idx_q, idx_d;
  logic              pend_q, pend_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  rx_rec_t           rec_q, rec_d;
  logic              win_clr;
  logic              accept;
  logic [WIN_W-1:0]  win;
  rx_rec_t           split_rec;

  rx_window #(.WIN_W(WIN_W)) u_window (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (win_clr),
    .shift_en(pend_q),
    .din     (mem_rdata),
    .win     (win)
  );

  rx_split u_split (
    .win    (win),
    .wide   (wide_q),
    .bit_sel(bit_q),
    .rec    (split_rec)
  );

  assign accept    = start && (st_q == ST_IDLE);
  assign mem_rd_en = (st_q == ST_RD);
  assign mem_addr  = addr_q + ADDR_W'(idx_q);

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    bit_d   = bit_q;
    wide_d  = wide_q;
    idx_d   = idx_q;
    err_d   = err_q;
    rec_d   = rec_q;
    done_d  = 1'b0;
    win_clr = 1'b0;
    pend_d  = mem_rd_en;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (loc_over) begin
            err_d  = 1'b1;
            rec_d  = '0;
            done_d = 1'b1;
          end else begin
            addr_d  = loc_addr;
            bit_d   = loc_bit;
            wide_d  = loc_wide;
            idx_d   = 2'd0;
            win_clr = 1'b1;
            st_d    = ST_RD;
          end
        end
      end
      ST_RD: begin
        idx_d = idx_q + 2'd1;
        if (idx_q == (wide_q ? 2'd2 : 2'd1)) st_d = ST_TAIL;
      end
      ST_TAIL: st_d = ST_OUT;
      ST_OUT: begin
        rec_d  = split_rec;
        err_d  = 1'b0;
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      bit_q  <= '0;
      wide_q <= 1'b0;
      idx_q  <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rec_q  <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      bit_q  <= bit_d;
      wide_q <= wide_d;
      idx_q  <= idx_d;
      pend_q <= pend_d;
      done_q <= done_d;
      err_q  <= err_d;
      rec_q  <= rec_d;
    end
  end

  assign done    = done_q;
  assign err     = err_q;
  assign fld_hi  = rec_q.hi;
  assign fld_mid = rec_q.mid;
  assign fld_lo  = rec_q.lo;

  AST_ERR_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && err) |-> (fld_hi == '0 && fld_mid == '0 && fld_lo == '0)); // R6
  AST_ERR_NO_READ: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && loc_over) |=> !mem_rd_en); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1))); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !done |-> $stable({err, fld_hi, fld_mid, fld_lo})); // R9
endmodule

// File: tb/sim_rx_rec_extract.sv
module sim_rx_rec_extract;
  localparam int PERIOD  = 10;
  localparam int ADDR_W  = 10;
  localparam int NUM_W   = 8;
  localparam int MAX_REC = 60;
  localparam int MEM_N   = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic [NUM_W-1:0]  rec_num = '0;
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_rdata;
  logic              done, err;
  logic [3:0]        fld_hi;
  logic [4:0]        fld_mid;
  logic [1:0]        fld_lo;

  logic [7:0] mem [0:MEM_N-1];
  int n_run = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

  rx_rec_extract #(.ADDR_W(ADDR_W), .NUM_W(NUM_W), .MAX_REC(MAX_REC)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .rec_num(rec_num),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .err(err), .fld_hi(fld_hi), .fld_mid(fld_mid), .fld_lo(fld_lo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int rbit(int p, int b);
    int a = (b + p / 8) % MEM_N;
    return (int'(mem[a]) >> (7 - p % 8)) & 1;
  endfunction

  // one access; poke = issue a second start while busy
  task automatic xact(input int b, input int n, input bit poke);
    int bo, nb, rec, e1, e2, e3, a0;
    bit e;
    e  = (n > MAX_REC);
    bo = n * 11;
    nb = ((bo % 8) <= 5) ? 2 : 3;
    rec = 0;
    for (int j = 0; j < 11; j++) rec = (rec << 1) | rbit(bo + j, b);  // R1
    e1 = (rec >> 7) & 15; e2 = (rec >> 2) & 31; e3 = rec & 3;         // R2
    a0 = (b + bo / 8) % MEM_N;
    @(negedge clk);
    base_addr = ADDR_W'(b); rec_num = NUM_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (e) begin
      chk(done == 1'b1, "R7 error done latency", int'(done), 1);
      chk(err == 1'b1, "R5 error flag", int'(err), 1);
      chk(mem_rd_en == 1'b0, "R5 no read on error", int'(mem_rd_en), 0);
      chk({fld_hi, fld_mid, fld_lo} == 11'd0, "R6 fields zero", int'({fld_hi, fld_mid, fld_lo}), 0);
    end else begin
      for (int c = 0; c < nb + 2; c++) begin
        if (poke && c == 0) begin start = 1'b1; rec_num = NUM_W'(MAX_REC + 5); end
        else start = 1'b0;
        chk(mem_rd_en == (c < nb), "R4 read count", int'(mem_rd_en), int'(c < nb));
        if (c < nb) chk(mem_addr == ADDR_W'(a0 + c), "R3 read address", int'(mem_addr), (a0 + c) % MEM_N);
        chk(done == 1'b0, "R7 early done", int'(done), 0);
        @(negedge clk);
      end
      start = 1'b0;
      chk(done == 1'b1, "R7 done latency", int'(done), 1);
      chk(err == 1'b0, poke ? "R8 busy start ignored" : "R6 err clear", int'(err), 0);
      chk(fld_hi == 4'(e1), "R2 fld_hi", int'(fld_hi), e1);
      chk(fld_mid == 5'(e2), "R2 fld_mid", int'(fld_mid), e2);
      chk(fld_lo == 2'(e3), "R2 fld_lo", int'(fld_lo), e3);
    end
    for (int h = 0; h < 2; h++) begin
      @(negedge clk);
      chk(done == 1'b0, "R7 done single cycle", int'(done), 0);
      chk(err == e && fld_hi == 4'(e ? 0 : e1) && fld_mid == 5'(e ? 0 : e2) && fld_lo == 2'(e ? 0 : e3),
          "R9 outputs held", int'({err, fld_hi, fld_mid, fld_lo}), int'({e, 4'(e ? 0 : e1), 5'(e ? 0 : e2), 2'(e ? 0 : e3)}));
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEM_N; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 2) ^ (i * i));
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && mem_rd_en == 1'b0 && err == 1'b0, "R7 reset state", int'({done, mem_rd_en, err}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done == 1'b0 && mem_rd_en == 1'b0, "R9 idle after reset", int'({done, mem_rd_en}), 0);
    // every start bit 0..7 (11k mod 8 cycles through all)
    for (int k = 0; k < 8; k++) xact(0, k, 1'b0);                // R4
    xact(100, 13, 1'b0);
    xact(1020, 9, 1'b0);                                          // R3 address wrap
    xact(37, MAX_REC, 1'b0);                                      // R6 at limit
    xact(37, MAX_REC + 1, 1'b0);                                  // R5
    xact(5, 255, 1'b0);                                           // R5
    xact(200, 2, 1'b1);                                           // R8
    xact(300, 6, 1'b1);                                           // R8
    xact(64, 31, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule